// File: doc/BRIEF.md
# Circular Reorder Buffer

This block keeps the instructions of an out-of-order core in program order so that their results retire in that order. It is a ring of slots with a head and a tail pointer. Each pointer carries one extra wrap bit, so a full ring and an empty ring can be told apart. Dispatch claims the slot at the tail and receives that slot's index as a tag. Execution units later report completion against that tag in any order. A completion can mark the entry as resting on an unresolved prediction, or as having raised an exception.

Each cycle the head looks at up to `RET_W` consecutive slots. Every finished, non-speculative, fault-free entry in that run commits, and its destination and result are presented on one commit lane. A speculative entry stops the run until a resolve with a correct outcome clears its flag. A resolve with a wrong outcome removes every entry younger than the resolved one, without committing them.

When a faulting entry reaches the head with all older entries gone, the older entries commit and everything younger is removed. The faulting entry itself commits or is removed, depending on the class reported with the fault. A flush pulse tells the surrounding core that entries were discarded and why. The core keeps the register values and the rename state elsewhere.

Top module: `reorder_ring`

## Requirements
- R1: After reset the ring is empty: `alloc_ready` is 1, `alloc_idx` is 0, `cmt_valid` is all zero and `flush` is 0.
- R2: A request with `alloc_valid` high while `alloc_ready` is high is accepted at the clock edge. Accepted requests receive slot indices `alloc_idx` that increase by one modulo `DEPTH`.
- R3: `alloc_ready` is low while `DEPTH` entries are held, and in any cycle in which a flush is being taken. A request made while it is low leaves the ring unchanged.
- R4: Completions may arrive in any order. An entry commits only when it has completed and every older entry has committed before or commits in the same cycle. The commit lane carries the destination given at dispatch and the data given at completion.
- R5: At most `RET_W` entries commit per clock edge. The commit outputs are registered and hold during the cycle after that edge. Lane 0 carries the oldest entry, and the valid lanes form a contiguous run starting at lane 0.
- R6: An entry completed with `done_spec`=1 does not commit, nor does anything younger, until `rsv_valid` with `rsv_wrong`=0 names it.
- R7: `rsv_valid` with `rsv_wrong`=1 on index i removes all entries younger than i without committing them, and clears the speculative flag of i itself. `flush`=1 with `flush_exc`=0 follows in the next cycle, and the next accepted allocation receives index i+1.
- R8: A completed, non-speculative entry that has `done_exc`=1 and reaches the head commit run removes every younger entry. If `done_exc_keep` is 1 it commits in that run; if it is 0 it is removed too. `flush`=1 with `flush_exc`=1 follows, and the ring is then empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_dest | input | DEST_W | Destination register of the dispatched instruction |
| alloc_ready | output | 1 | A request is accepted this cycle |
| alloc_idx | output | IDX_W | Slot index given to an accepted request |
| done_valid | input | 1 | An execution unit reports completion |
| done_idx | input | IDX_W | Slot index of the completed entry |
| done_data | input | DATA_W | Result of the completed entry |
| done_spec | input | 1 | Completed entry rests on an unresolved prediction |
| done_exc | input | 1 | Completed entry raised an exception |
| done_exc_keep | input | 1 | The faulting entry itself commits (1) or is removed (0) |
| rsv_valid | input | 1 | A prediction is resolved |
| rsv_idx | input | IDX_W | Slot index of the resolved entry |
| rsv_wrong | input | 1 | The prediction was wrong |
| cmt_valid | output | RET_W | Per-lane commit valid, lane 0 oldest |
| cmt_dest | output | RET_W*DEST_W | Per-lane destination, lane k at bits k*DEST_W |
| cmt_data | output | RET_W*DATA_W | Per-lane result, lane k at bits k*DATA_W |
| flush | output | 1 | Entries were removed without commit |
| flush_exc | output | 1 | Cause of the flush: 1 exception, 0 misprediction |

## Verification
The bench fills the ring and then offers one more entry; a design that miscounted with its wrap bit would overwrite the oldest slot or lock up. It completes entries in reverse order and parks a speculative entry between finished ones, so a design that skipped the age check would commit past a gap or a pending prediction. It resolves a wrong prediction while an older entry commits in the same edge, and checks that the next tag follows the resolved slot; a wrong tail rewind would either lose that commit or reissue removed tags. It raises faults of both classes behind a committing neighbour; a design that confused the classes would commit a removed instruction or lose a kept one.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        SL_EMPTY     = 2'd0,
        SL_ISSUED    = 2'd1,
        SL_DONE      = 2'd2,
        SL_DONE_SPEC = 2'd3
    } slot_st_e;
endpackage

// File: rtl/rob_commit_scan.sv
// Walks the oldest RET_W slots and marks the run that may leave this cycle.
module rob_commit_scan #(
    parameter int DEPTH = 8,
    parameter int RET_W = 2,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]  head_idx,
    input  rob_pkg::slot_st_e st   [DEPTH],
    input  logic              exc  [DEPTH],
    input  logic              keep [DEPTH],
    output logic [RET_W-1:0]  take,
    output logic              fault
);
    logic             blocked;
    logic [IDX_W-1:0] sidx;

    always_comb begin
        take    = '0;
        fault   = 1'b0;
        blocked = 1'b0;
        sidx    = '0;
        for (int k = 0; k < RET_W; k++) begin
            sidx = head_idx + IDX_W'(k);
            if (!blocked) begin
                if (st[sidx] == rob_pkg::SL_DONE) begin
                    if (!exc[sidx]) begin
                        take[k] = 1'b1;
                    end else begin
                        take[k] = keep[sidx];
                        fault   = 1'b1;
                        blocked = 1'b1;
                    end
                end else begin
                    blocked = 1'b1;
                end
            end
        end
    end

    // R5: the run that leaves is contiguous from the oldest lane
    always_comb begin
        assert_take_contig_R5: assert (((RET_W'(take + 1'b1)) & take) == '0);
    end
endmodule

// File: rtl/rob_younger.sv
// One comparator per slot: is this slot younger than the pivot entry?
module rob_younger #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] head_idx,
    input  logic [IDX_W-1:0] pivot_idx,
    output logic [DEPTH-1:0] younger
);
    logic [IDX_W-1:0] pivot_off;
    assign pivot_off = pivot_idx - head_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        logic [IDX_W-1:0] off;
        assign off        = IDX_W'(g) - head_idx;
        assign younger[g] = off > pivot_off;
    end
endmodule

// File: rtl/reorder_ring.sv
module reorder_ring #(
    parameter int DEPTH  = 8,
    parameter int RET_W  = 2,
    parameter int DEST_W = 5,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_valid,
    input  logic [DEST_W-1:0]       alloc_dest,
    output logic                    alloc_ready,
    output logic [IDX_W-1:0]        alloc_idx,
    input  logic                    done_valid,
    input  logic [IDX_W-1:0]        done_idx,
    input  logic [DATA_W-1:0]       done_data,
    input  logic                    done_spec,
    input  logic                    done_exc,
    input  logic                    done_exc_keep,
    input  logic                    rsv_valid,
    input  logic [IDX_W-1:0]        rsv_idx,
    input  logic                    rsv_wrong,
    output logic [RET_W-1:0]        cmt_valid,
    output logic [RET_W*DEST_W-1:0] cmt_dest,
    output logic [RET_W*DATA_W-1:0] cmt_data,
    output logic                    flush,
    output logic                    flush_exc
);
    import rob_pkg::*;

    localparam int PTR_W = IDX_W + 1;

    typedef struct packed {
        slot_st_e          st;
        logic              exc;
        logic              keep;
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0]        slot;
        logic [PTR_W-1:0]         head;
        logic [PTR_W-1:0]         tail;
        logic [RET_W-1:0]         cv;
        logic [RET_W*DEST_W-1:0]  cd;
        logic [RET_W*DATA_W-1:0]  cdat;
        logic                     fl;
        logic                     fx;
    } ring_t;

    ring_t s_d, s_q;

    slot_st_e          st_arr   [DEPTH];
    logic              exc_arr  [DEPTH];
    logic              keep_arr [DEPTH];
    logic [RET_W-1:0]  take;
    logic              fault;
    logic [DEPTH-1:0]  younger;
    logic [PTR_W-1:0]  count_q;
    logic              full;
    logic              wrong_now;
    logic [IDX_W-1:0]  head_idx;
    logic [IDX_W-1:0]  rsv_off;
    logic [PTR_W-1:0]  ncommit;
    logic [IDX_W-1:0]  lane_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_view
        assign st_arr[g]   = s_q.slot[g].st;
        assign exc_arr[g]  = s_q.slot[g].exc;
        assign keep_arr[g] = s_q.slot[g].keep;
    end

    assign head_idx  = s_q.head[IDX_W-1:0];
    assign count_q   = s_q.tail - s_q.head;
    assign full      = count_q == PTR_W'(DEPTH);
    assign wrong_now = rsv_valid && rsv_wrong;
    assign rsv_off   = rsv_idx - head_idx;

    rob_commit_scan #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W)) u_scan (
        .head_idx (head_idx),
        .st       (st_arr),
        .exc      (exc_arr),
        .keep     (keep_arr),
        .take     (take),
        .fault    (fault)
    );

    rob_younger #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_age (
        .head_idx  (head_idx),
        .pivot_idx (rsv_idx),
        .younger   (younger)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cv   = take;
        s_d.fl   = 1'b0;
        s_d.fx   = 1'b0;
        ncommit  = '0;
        lane_idx = '0;

        // commit lanes read the registered slots
        for (int k = 0; k < RET_W; k++) begin
            lane_idx = head_idx + IDX_W'(k);
            s_d.cd[k*DEST_W +: DEST_W]   = s_q.slot[lane_idx].dest;
            s_d.cdat[k*DATA_W +: DATA_W] = s_q.slot[lane_idx].data;
            ncommit = ncommit + PTR_W'(take[k]);
        end

        // out-of-order completion
        if (done_valid && s_q.slot[done_idx].st == SL_ISSUED) begin
            s_d.slot[done_idx].st   = done_spec ? SL_DONE_SPEC : SL_DONE;
            s_d.slot[done_idx].data = done_data;
            s_d.slot[done_idx].exc  = done_exc;
            s_d.slot[done_idx].keep = done_exc_keep;
        end

        // resolution clears the flag of the resolved entry itself
        if (rsv_valid && s_q.slot[rsv_idx].st == SL_DONE_SPEC) begin
            s_d.slot[rsv_idx].st = SL_DONE;
        end

        for (int k = 0; k < RET_W; k++) begin
            lane_idx = head_idx + IDX_W'(k);
            if (take[k]) s_d.slot[lane_idx].st = SL_EMPTY;
        end
        s_d.head = s_q.head + ncommit;

        if (fault) begin
            for (int g = 0; g < DEPTH; g++) s_d.slot[g].st = SL_EMPTY;
            s_d.tail = s_d.head;
            s_d.fl   = 1'b1;
            s_d.fx   = 1'b1;
        end else if (wrong_now) begin
            for (int g = 0; g < DEPTH; g++) begin
                if (younger[g]) s_d.slot[g].st = SL_EMPTY;
            end
            s_d.tail = s_q.head + PTR_W'(rsv_off) + PTR_W'(1);
            s_d.fl   = 1'b1;
        end else if (alloc_valid && !full) begin
            s_d.slot[s_q.tail[IDX_W-1:0]] = '{st: SL_ISSUED, exc: 1'b0, keep: 1'b0,
                                              dest: alloc_dest, data: '0};
            s_d.tail = s_q.tail + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign alloc_ready = !full && !fault && !wrong_now;
    assign alloc_idx   = s_q.tail[IDX_W-1:0];
    assign cmt_valid   = s_q.cv;
    assign cmt_dest    = s_q.cd;
    assign cmt_data    = s_q.cdat;
    assign flush       = s_q.fl;
    assign flush_exc   = s_q.fx;

    // R3: the ring never holds more than DEPTH entries
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= PTR_W'(DEPTH));

    // R5: the head moves by exactly the number of lanes shown
    assert_head_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s_q.head - $past(s_q.head)) == PTR_W'($countones(cmt_valid)));

    // R8: after an exception flush nothing is left in the ring
    assert_fault_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_exc |-> count_q == '0);

    // R7: a misprediction flush never leaves the ring over-full
    assert_wrong_keeps_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !flush_exc) |-> count_q <= PTR_W'(DEPTH));
endmodule

// File: tb/reorder_ring_test.sv
module reorder_ring_test;
    localparam int DEPTH  = 8;
    localparam int RET_W  = 2;
    localparam int DEST_W = 5;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [DEST_W-1:0] alloc_dest = '0;
    logic alloc_ready;
    logic [IDX_W-1:0] alloc_idx;
    logic done_valid = 1'b0;
    logic [IDX_W-1:0] done_idx = '0;
    logic [DATA_W-1:0] done_data = '0;
    logic done_spec = 1'b0, done_exc = 1'b0, done_exc_keep = 1'b0;
    logic rsv_valid = 1'b0;
    logic [IDX_W-1:0] rsv_idx = '0;
    logic rsv_wrong = 1'b0;
    logic [RET_W-1:0] cmt_valid;
    logic [RET_W*DEST_W-1:0] cmt_dest;
    logic [RET_W*DATA_W-1:0] cmt_data;
    logic flush, flush_exc;

    always #2 clk = ~clk;

    reorder_ring #(.DEPTH(DEPTH), .RET_W(RET_W), .DEST_W(DEST_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .done_valid(done_valid), .done_idx(done_idx), .done_data(done_data),
        .done_spec(done_spec), .done_exc(done_exc), .done_exc_keep(done_exc_keep),
        .rsv_valid(rsv_valid), .rsv_idx(rsv_idx), .rsv_wrong(rsv_wrong),
        .cmt_valid(cmt_valid), .cmt_dest(cmt_dest), .cmt_data(cmt_data),
        .flush(flush), .flush_exc(flush_exc)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model: 0 empty, 1 issued, 2 done, 3 done speculative
    int mst [DEPTH];
    bit mexc [DEPTH];
    bit mkeep [DEPTH];
    logic [DEST_W-1:0] mdest [DEPTH];
    logic [DATA_W-1:0] mdata [DEPTH];
    int mhead = 0;
    int mtail = 0;
    int commits_seen = 0;

    function automatic int wrapi(input int x);
        return ((x % DEPTH) + DEPTH) % DEPTH;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // one cycle: drive at negedge, check combinational outputs, then registered ones
    task automatic step(input bit av, input int ad, input bit dv, input int di,
                        input int dd, input bit ds, input bit de, input bit dk,
                        input bit rv, input int ri, input bit rw);
        int cnt;
        int oldst [DEPTH];
        int oldhead;
        int nc;
        int roff;
        bit [RET_W-1:0] take;
        bit fault;
        bit blk;
        bit exp_ready;
        logic [DEST_W-1:0] ecd [RET_W];
        logic [DATA_W-1:0] ecdat [RET_W];
        alloc_valid = av; alloc_dest = DEST_W'(ad);
        done_valid = dv; done_idx = IDX_W'(di); done_data = DATA_W'(dd);
        done_spec = ds; done_exc = de; done_exc_keep = dk;
        rsv_valid = rv; rsv_idx = IDX_W'(ri); rsv_wrong = rw;
        #1;
        cnt = mtail - mhead;
        take = '0; fault = 0; blk = 0;
        for (int k = 0; k < RET_W; k++) begin
            int s;
            s = wrapi(mhead + k);
            ecd[k] = mdest[s];
            ecdat[k] = mdata[s];
            if (!blk) begin
                if (mst[s] == 2) begin
                    if (!mexc[s]) take[k] = 1'b1;
                    else begin take[k] = mkeep[s]; fault = 1; blk = 1; end
                end else blk = 1;
            end
        end
        exp_ready = (cnt < DEPTH) && !fault && !(rv && rw);
        chk(alloc_ready === exp_ready, "R3", "alloc_ready", alloc_ready, exp_ready);
        if (exp_ready) chk(alloc_idx == IDX_W'(wrapi(mtail)), "R2", "alloc_idx",
                           alloc_idx, wrapi(mtail));
        // model next state
        for (int g = 0; g < DEPTH; g++) oldst[g] = mst[g];
        oldhead = mhead;
        if (dv && oldst[di] == 1) begin
            mst[di] = ds ? 3 : 2; mdata[di] = DATA_W'(dd); mexc[di] = de; mkeep[di] = dk;
        end
        if (rv && oldst[ri] == 3) mst[ri] = 2;
        nc = 0;
        for (int k = 0; k < RET_W; k++) begin
            if (take[k]) begin mst[wrapi(oldhead + k)] = 0; nc++; end
        end
        mhead = oldhead + nc;
        if (fault) begin
            for (int g = 0; g < DEPTH; g++) mst[g] = 0;
            mtail = mhead;
        end else if (rv && rw) begin
            roff = wrapi(ri - oldhead);
            for (int g = 0; g < DEPTH; g++) if (wrapi(g - oldhead) > roff) mst[g] = 0;
            mtail = oldhead + roff + 1;
        end else if (av && cnt < DEPTH) begin
            int t;
            t = wrapi(mtail);
            mst[t] = 1; mdest[t] = DEST_W'(ad); mdata[t] = '0; mexc[t] = 0; mkeep[t] = 0;
            mtail++;
        end
        @(posedge clk); #1;
        chk(cmt_valid == take, "R5", "cmt_valid", cmt_valid, take);
        for (int k = 0; k < RET_W; k++) begin
            if (take[k]) begin
                commits_seen++;
                chk(cmt_dest[k*DEST_W +: DEST_W] == ecd[k], "R4", "cmt_dest",
                    cmt_dest[k*DEST_W +: DEST_W], ecd[k]);
                chk(cmt_data[k*DATA_W +: DATA_W] == ecdat[k], "R4", "cmt_data",
                    cmt_data[k*DATA_W +: DATA_W], ecdat[k]);
            end
        end
        chk(flush == (fault || (rv && rw)), fault ? "R8" : "R7", "flush", flush,
            fault || (rv && rw));
        chk(flush_exc == fault, "R8", "flush_exc", flush_exc, fault);
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic alloc(input int d);
        step(1, d, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic complete(input int i, input int d, input bit s, input bit e, input bit k);
        step(0, 0, 1, i, d, s, e, k, 0, 0, 0);
    endtask

    function automatic int pick(input int want);
        int start;
        start = int'($urandom % DEPTH);
        for (int j = 0; j < DEPTH; j++) if (mst[wrapi(start + j)] == want) return wrapi(start + j);
        return -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R5 watchdog: got 0 expected 1 (run ended)");
            report();
        end
    end

    initial begin
        int base;
        void'($urandom(32'd2024));
        for (int g = 0; g < DEPTH; g++) begin
            mst[g] = 0; mexc[g] = 0; mkeep[g] = 0; mdest[g] = '0; mdata[g] = '0;
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(alloc_ready == 1'b1, "R1", "alloc_ready", alloc_ready, 1);
        chk(alloc_idx == '0, "R1", "alloc_idx", alloc_idx, 0);
        chk(cmt_valid == '0, "R1", "cmt_valid", cmt_valid, 0);
        chk(flush == 1'b0, "R1", "flush", flush, 0);
        @(negedge clk);

        // fill, then one request while full (R3)
        for (int i = 0; i < DEPTH; i++) alloc(i);
        chk(alloc_ready == 1'b0, "R3", "ready when full", alloc_ready, 0);
        alloc(31);
        // reverse-order completion (R4)
        for (int i = DEPTH - 1; i >= 1; i--) complete(i, 100 + i, 0, 0, 0);
        chk(cmt_valid == '0, "R4", "no commit with head open", cmt_valid, 0);
        complete(0, 100, 0, 0, 0);
        commits_seen = 0;
        idle();
        chk(cmt_valid == 2'b11, "R5", "two lanes at once", cmt_valid, 3);
        repeat (4) idle();
        chk(commits_seen == DEPTH, "R5", "drained count", commits_seen, DEPTH);

        // speculative entry blocks (R6): slots 0,1,2
        alloc(10); alloc(11); alloc(12);
        complete(1, 201, 1, 0, 0);
        complete(0, 200, 0, 0, 0);
        complete(2, 202, 0, 0, 0);
        idle();
        chk(cmt_valid == 2'b00, "R6", "blocked by speculation", cmt_valid, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        idle();
        chk(cmt_valid == 2'b11, "R6", "released after resolve", cmt_valid, 3);

        // wrong prediction (R7): slots 3..6, branch at 4
        alloc(13); alloc(14); alloc(15); alloc(16);
        complete(4, 304, 1, 0, 0);
        complete(3, 303, 0, 0, 0);
        step(0, 0, 1, 5, 305, 0, 0, 0, 1, 4, 1);
        chk(flush == 1'b1 && flush_exc == 1'b0, "R7", "misprediction flush",
            {flush, flush_exc}, 2);
        chk(alloc_idx == 3'd5, "R7", "tail rewound", alloc_idx, 5);
        idle();
        chk(cmt_valid == 2'b01 && cmt_dest[DEST_W-1:0] == 5'd14, "R7", "branch kept",
            cmt_dest[DEST_W-1:0], 14);

        // exception, faulting entry removed (R8): slots 5,6,7
        alloc(20); alloc(21); alloc(22);
        complete(6, 406, 0, 1, 0);
        complete(7, 407, 0, 0, 0);
        complete(5, 405, 0, 0, 0);
        idle();
        chk(flush_exc == 1'b1 && cmt_valid == 2'b01, "R8", "fault removed",
            cmt_valid, 1);
        chk(alloc_idx == 3'd6, "R8", "ring empty after fault", alloc_idx, 6);

        // exception, faulting entry kept (R8): slots 6,7
        alloc(23); alloc(24);
        complete(7, 507, 0, 0, 0);
        complete(6, 506, 0, 1, 1);
        idle();
        chk(flush_exc == 1'b1 && cmt_valid == 2'b01 && cmt_dest[DEST_W-1:0] == 5'd23,
            "R8", "fault kept", cmt_dest[DEST_W-1:0], 23);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            bit av, dv, ds, de, dk, rv, rw;
            int di, ri;
            av = ($urandom % 4) != 0;
            di = pick(1);
            dv = (di >= 0) && (($urandom % 10) < 7);
            if (di < 0) di = 0;
            ds = ($urandom % 4) == 0;
            de = ($urandom % 25) == 0;
            dk = $urandom % 2;
            ri = pick(3);
            rv = (ri >= 0) && (($urandom % 10) < 4);
            if (ri < 0) ri = 0;
            rw = ($urandom % 10) < 3;
            step(av, int'($urandom % 32), dv, di, int'($urandom % 65536), ds, de, dk,
                 rv, ri, rw);
        end
        report();
    end
endmodule